// File: doc/BRIEF.md
# Lockstep Node-Sequence Watchdog

This block checks a monitored processor's control flow as it runs. Before checking starts, a small checking program is written into the watchdog's own memory through a setup port. The program holds one entry per node of the monitored code, where a node is a branch-free stretch of instruction words. Each entry records how many words the node spans, what follows the node, and, for nodes that close a path, the expected XOR signature of every word fetched along that path.

During the checking phase the watchdog moves in step with the processor. Every fetch strobe advances a per-node word counter and folds the fetched word into a running signature. A branch indication arrives together with a node's final fetch. The watchdog uses it to take the same successor that the processor took. A node that ends too early or too late raises the error flag on that fetch. At a verifying node the running signature is compared with the stored one. A match gives a one-cycle path-verified pulse and a mismatch raises the error flag. Dropping the enable ends checking and re-arms the block from address zero.

Top module: `wdseq_top`

## Requirements
- R1: After reset, and on the cycle after any cycle with `chk_en_i` low, `err_o` and `path_ok_o` are 0, the program address is 0 and the running signature is 0.
- R2: A program word packs the opcode in bits [26:24], node length minus one in [23:20], successor address in [19:16] and signature in [15:0]. The opcodes are 0 plain, 1 load-signature, 2 branch, 3 branch-and-verify and 4 restart. Codes 5 to 7 are illegal and raise `err_o` on the node's first fetch.
- R3: A setup write stores `cfg_data_i` at `cfg_addr_i` only while `chk_en_i` is low. While checking is active the write is ignored.
- R4: Each accepted fetch XORs `fetch_word_i` into the running signature. A load-signature node zeroes the signature before its first word.
- R5: On the final fetch of a branch-and-verify node, the signature including that word is compared with the node's signature field. If they are equal, `path_ok_o` pulses for one cycle. If they differ, `err_o` is set.
- R6: At the end of a branch node or a branch-and-verify node, a taken branch goes to the successor address and a not-taken branch goes to the next address. Plain and load-signature nodes always go to the next address.
- R7: `br_vld_i` with a fetch that is not the final word of a branch-type node raises `err_o`.
- R8: The final fetch of a branch-type node without `br_vld_i` raises `err_o`, because the processor ran past the stored length.
- R9: At the end of a restart node the program address returns to 0 and the running signature is cleared.
- R10: `err_o` stays set while `chk_en_i` is high. After an error no further `path_ok_o` pulses occur until checking is re-enabled.
- R11: `err_o` and `path_ok_o` change only in the cycle after the clock edge that samples the causing fetch. A cycle without a fetch leaves `err_o` unchanged and `path_ok_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en_i | input | 1 | Checking phase active |
| cfg_we_i | input | 1 | Setup write strobe |
| cfg_addr_i | input | 4 | Setup write address |
| cfg_data_i | input | 27 | Setup write data (program word) |
| fetch_vld_i | input | 1 | Monitored processor fetched a word |
| fetch_word_i | input | 16 | Fetched instruction word |
| br_vld_i | input | 1 | Branch decision accompanies this fetch |
| br_taken_i | input | 1 | Branch was taken |
| err_o | output | 1 | Sticky control-flow error |
| path_ok_o | output | 1 | One-cycle pulse on a verified path |

## Verification
A wrong program address shows up as the wrong length or signature for the next node. The first fetch that disagrees raises `err_o` one cycle later, or the next verify fails. A corrupted running signature stays hidden until the path's verifying node. It then appears as an error where a pulse was expected. An off-by-one word counter flags the node boundary at once through the early-branch or missing-branch errors. The tests therefore pair each stimulus with the exact cycle where the flag or pulse must appear, and they use branch paths whose signatures differ so that a wrong successor cannot pass unnoticed.

// File: rtl/wdseq_pkg.sv
package wdseq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ = 3'd0,
    OP_LDS = 3'd1,
    OP_BR  = 3'd2,
    OP_BRV = 3'd3,
    OP_RST = 3'd4
  } wd_op_e;
endpackage

// File: rtl/wdseq_prog_mem.sv
module wdseq_prog_mem #(
  parameter int AW = 4,
  parameter int IW = 27
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wdseq_decode.sv
module wdseq_decode
  import wdseq_pkg::*;
#(
  parameter int LW = 4,
  parameter int AW = 4,
  parameter int SW = 16
) (
  input  logic [OP_W+LW+AW+SW-1:0] instr,
  output wd_op_e                   op,
  output logic [LW-1:0]            len_m1,
  output logic [AW-1:0]            tgt,
  output logic [SW-1:0]            sig,
  output logic                     illegal
);
  localparam int IW = OP_W + LW + AW + SW;

  logic [OP_W-1:0] op_raw;

  assign op_raw  = instr[IW-1 -: OP_W];
  assign len_m1  = instr[SW+AW +: LW];
  assign tgt     = instr[SW +: AW];
  assign sig     = instr[SW-1:0];
  assign illegal = (op_raw > OP_RST);
  assign op      = illegal ? OP_SEQ : wd_op_e'(op_raw);
endmodule

// File: rtl/wdseq_node_ctr.sv
module wdseq_node_ctr #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [LW-1:0] len_m1,
  output logic          first,
  output logic          last
);
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | step;
    cnt_d  = clr ? '0 : cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == len_m1);
endmodule

// File: rtl/wdseq_sig_acc.sv
module wdseq_sig_acc #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          restart,
  input  logic [SW-1:0] word,
  output logic [SW-1:0] s_nxt
);
  logic [SW-1:0] s_q;
  logic [SW-1:0] s_d;
  logic          s_en;

  always_comb begin
    s_nxt = (restart ? '0 : s_q) ^ word;
    s_en  = clr | upd;
    s_d   = clr ? '0 : s_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
    end else if (s_en) begin
      s_q <= s_d;
    end
  end
endmodule

// File: rtl/wdseq_top.sv
module wdseq_top
  import wdseq_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = 4,
  parameter int SW = 16,
  localparam int IW = OP_W + LW + AW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [IW-1:0] cfg_data_i,
  input  logic          fetch_vld_i,
  input  logic [SW-1:0] fetch_word_i,
  input  logic          br_vld_i,
  input  logic          br_taken_i,
  output logic          err_o,
  output logic          path_ok_o
);
  logic [AW-1:0] pc_q, pc_d;
  logic          err_q, err_d;
  logic          pok_q, pok_d;

  logic [IW-1:0] instr;
  wd_op_e        op;
  logic [LW-1:0] len_m1;
  logic [AW-1:0] tgt;
  logic [SW-1:0] sig;
  logic          illegal;
  logic          first, last;
  logic [SW-1:0] s_nxt;

  logic acc, br_node, fail, node_done;
  logic f_ill, f_early, f_miss, f_sig;

  wdseq_prog_mem #(.AW(AW), .IW(IW)) u_mem (
    .clk   (clk),
    .we    (cfg_we_i & ~chk_en_i),
    .waddr (cfg_addr_i),
    .wdata (cfg_data_i),
    .raddr (pc_q),
    .rdata (instr)
  );

  wdseq_decode #(.LW(LW), .AW(AW), .SW(SW)) u_dec (
    .instr   (instr),
    .op      (op),
    .len_m1  (len_m1),
    .tgt     (tgt),
    .sig     (sig),
    .illegal (illegal)
  );

  wdseq_node_ctr #(.LW(LW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~chk_en_i | node_done),
    .step   (acc & ~fail),
    .len_m1 (len_m1),
    .first  (first),
    .last   (last)
  );

  wdseq_sig_acc #(.SW(SW)) u_sig (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~chk_en_i | (node_done & (op == OP_RST))),
    .upd     (acc & ~fail),
    .restart ((op == OP_LDS) & first),
    .word    (fetch_word_i),
    .s_nxt   (s_nxt)
  );

  // Fault detection and sequencing
  always_comb begin
    acc       = chk_en_i & ~err_q & fetch_vld_i;
    br_node   = (op == OP_BR) | (op == OP_BRV);
    f_ill     = acc & illegal;
    f_early   = acc & br_vld_i & ~(last & br_node);
    f_miss    = acc & last & br_node & ~br_vld_i;
    f_sig     = acc & last & (op == OP_BRV) & br_vld_i & (s_nxt != sig);
    fail      = f_ill | f_early | f_miss | f_sig;
    node_done = acc & last & ~fail;
  end

  always_comb begin
    pc_d = pc_q;
    if (!chk_en_i) begin
      pc_d = '0;
    end else if (node_done) begin
      unique case (op)
        OP_BR, OP_BRV: pc_d = br_taken_i ? tgt : pc_q + AW'(1);
        OP_RST:        pc_d = '0;
        default:       pc_d = pc_q + AW'(1);
      endcase
    end
    err_d = chk_en_i & (err_q | fail);
    pok_d = node_done & (op == OP_BRV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      err_q <= 1'b0;
      pok_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
      pok_q <= pok_d;
    end
  end

  assign err_o     = err_q;
  assign path_ok_o = pok_q;
endmodule

// File: rtl/wdseq_chk.sv
module wdseq_chk (
  input logic clk,
  input logic rst_n,
  input logic chk_en_i,
  input logic fetch_vld_i,
  input logic br_vld_i,
  input logic err_o,
  input logic path_ok_o
);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && chk_en_i) |=> err_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |=> (!err_o && !path_ok_o));

  // R5
  ok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_ok_o |-> !err_o);

  // R5
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_ok_o |-> $past(fetch_vld_i && br_vld_i && chk_en_i));

  // R11
  nofetch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && !fetch_vld_i) |=> ($stable(err_o) && !path_ok_o));
endmodule

bind wdseq_top wdseq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chk_en_i    (chk_en_i),
  .fetch_vld_i (fetch_vld_i),
  .br_vld_i    (br_vld_i),
  .err_o       (err_o),
  .path_ok_o   (path_ok_o)
);

// File: tb/wdseq_top_bench.sv
module wdseq_top_bench;
  localparam int AW = 4;
  localparam int LW = 4;
  localparam int SW = 16;
  localparam int IW = 3 + LW + AW + SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chk_en_i;
  logic          cfg_we_i;
  logic [AW-1:0] cfg_addr_i;
  logic [IW-1:0] cfg_data_i;
  logic          fetch_vld_i;
  logic [SW-1:0] fetch_word_i;
  logic          br_vld_i;
  logic          br_taken_i;
  logic          err_o;
  logic          path_ok_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  wdseq_top #(.AW(AW), .LW(LW), .SW(SW)) u_wdseq_top (.*);

  task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic e_err, input logic e_ok);
    expect_bit(req, "err_o", err_o, e_err);
    expect_bit(req, "path_ok_o", path_ok_o, e_ok);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [2:0] op, input logic [LW-1:0] lm1,
                    input logic [AW-1:0] tgt, input logic [SW-1:0] sig);
    @(negedge clk);
    cfg_we_i   = 1'b1;
    cfg_addr_i = a;
    cfg_data_i = {op, lm1, tgt, sig};
    @(posedge clk);
    #2 cfg_we_i = 1'b0;
  endtask

  task automatic fetch(input logic [SW-1:0] w, input logic bv, input logic bt);
    @(negedge clk);
    fetch_vld_i  = 1'b1;
    fetch_word_i = w;
    br_vld_i     = bv;
    br_taken_i   = bt;
    @(posedge clk);
    #2;
    fetch_vld_i = 1'b0;
    br_vld_i    = 1'b0;
    br_taken_i  = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    chk_en_i = v;
    @(posedge clk);
    #2;
  endtask

  localparam logic [SW-1:0] W0 = 16'h1234, W1 = 16'h00F0, W2 = 16'hA5A5;
  localparam logic [SW-1:0] WA = 16'h0F0F, WB = 16'h3C3C, WC = 16'h5001, WD = 16'h7E02;

  task automatic load_line(input logic [SW-1:0] sig);
    wr(4'd0, 3'd1, 4'd1, 4'd0, 16'h0);
    wr(4'd1, 3'd3, 4'd0, 4'd0, sig);
  endtask

  task automatic t_reset();
    expect_out("R1", 1'b0, 1'b0);
  endtask

  task automatic t_line();
    logic [SW-1:0] s = W0 ^ W1 ^ W2;
    load_line(s);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0); expect_out("R4", 1'b0, 1'b0);
    idle();                expect_out("R11", 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0); expect_out("R4", 1'b0, 1'b0);
    fetch(W2, 1'b1, 1'b1); expect_out("R5", 1'b0, 1'b1);
    idle();                expect_out("R11", 1'b0, 1'b0);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0);
    fetch(W2, 1'b1, 1'b1); expect_out("R4", 1'b0, 1'b1);
    set_en(1'b0);
  endtask

  task automatic t_branch();
    wr(4'd0, 3'd1, 4'd0, 4'd0, 16'h0);
    wr(4'd1, 3'd2, 4'd0, 4'd3, 16'h0);
    wr(4'd2, 3'd3, 4'd0, 4'd0, WA ^ WB ^ WC);
    wr(4'd3, 3'd3, 4'd0, 4'd0, WA ^ WB ^ WD);
    set_en(1'b1);
    fetch(WA, 1'b0, 1'b0);
    fetch(WB, 1'b1, 1'b1);
    fetch(WD, 1'b1, 1'b1); expect_out("R6", 1'b0, 1'b1);
    fetch(WA, 1'b0, 1'b0);
    fetch(WB, 1'b1, 1'b0);
    fetch(WC, 1'b1, 1'b1); expect_out("R6", 1'b0, 1'b1);
    set_en(1'b0);
  endtask

  task automatic t_mismatch();
    load_line(W0 ^ W1 ^ W2);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0);
    fetch(W2 ^ 16'h0001, 1'b1, 1'b1); expect_out("R5", 1'b1, 1'b0);
    fetch(W0, 1'b0, 1'b0);            expect_out("R10", 1'b1, 1'b0);
    idle();                           expect_out("R10", 1'b1, 1'b0);
    set_en(1'b0);                     expect_out("R1", 1'b0, 1'b0);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0);
    fetch(W2, 1'b1, 1'b1);            expect_out("R10", 1'b0, 1'b1);
    set_en(1'b0);
  endtask

  task automatic t_length();
    load_line(W0 ^ W1 ^ W2);
    set_en(1'b1);
    fetch(W0, 1'b1, 1'b1); expect_out("R7", 1'b1, 1'b0);
    set_en(1'b0);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b1, 1'b0); expect_out("R7", 1'b1, 1'b0);
    set_en(1'b0);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0); expect_out("R8", 1'b0, 1'b0);
    fetch(W2, 1'b0, 1'b0); expect_out("R8", 1'b1, 1'b0);
    set_en(1'b0);
  endtask

  task automatic t_restart();
    wr(4'd0, 3'd0, 4'd0, 4'd0, 16'h0);
    wr(4'd1, 3'd2, 4'd0, 4'd3, 16'h0);
    wr(4'd2, 3'd4, 4'd0, 4'd0, 16'h0);
    wr(4'd3, 3'd3, 4'd0, 4'd0, WA ^ WB ^ WD);
    set_en(1'b1);
    fetch(WA, 1'b0, 1'b0);
    fetch(WB, 1'b1, 1'b0);
    fetch(WC, 1'b0, 1'b0); expect_out("R9", 1'b0, 1'b0);
    fetch(WA, 1'b0, 1'b0);
    fetch(WB, 1'b1, 1'b1);
    fetch(WD, 1'b1, 1'b1); expect_out("R9", 1'b0, 1'b1);
    set_en(1'b0);
  endtask

  task automatic t_illegal();
    wr(4'd0, 3'd6, 4'd0, 4'd0, 16'h0);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0); expect_out("R2", 1'b1, 1'b0);
    set_en(1'b0);
  endtask

  task automatic t_setup();
    logic [SW-1:0] s = W0 ^ W1 ^ W2;
    load_line(s);
    set_en(1'b1);
    wr(4'd1, 3'd3, 4'd0, 4'd0, ~s);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0);
    fetch(W2, 1'b1, 1'b1); expect_out("R3", 1'b0, 1'b1);
    set_en(1'b0);
    wr(4'd1, 3'd3, 4'd0, 4'd0, ~s);
    set_en(1'b1);
    fetch(W0, 1'b0, 1'b0);
    fetch(W1, 1'b0, 1'b0);
    fetch(W2, 1'b1, 1'b1); expect_out("R3", 1'b1, 1'b0);
    set_en(1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n        = 1'b0;
    chk_en_i     = 1'b0;
    cfg_we_i     = 1'b0;
    cfg_addr_i   = '0;
    cfg_data_i   = '0;
    fetch_vld_i  = 1'b0;
    fetch_word_i = '0;
    br_vld_i     = 1'b0;
    br_taken_i   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_line();
    t_branch();
    t_mismatch();
    t_length();
    t_restart();
    t_illegal();
    t_setup();
    finish_run();
  end
endmodule